// File: doc/BRIEF.md
# Upward-Growing Stack Engine

This block owns an 8-bit stack pointer. It sequences single-byte stack transfers against a byte-wide internal RAM port. A caller raises `start` for one cycle with an operation code and its operand. The block then runs the operation one RAM transfer per cycle and pulses `done` when the operation is finished. Instruction decode, interrupt arbitration and the RAM array itself sit outside the block.

The stack grows towards higher addresses. A push increments the pointer before it writes. A pop reads before it decrements. A push moves a byte from a direct address onto the stack, and a pop moves the top byte to a direct address. A call stores a 16-bit return address, and a return restores one, optionally also signalling that the interrupt-enable priority state must be restored. The pointer can also be loaded directly, in the way software writes it as a special register.

Top module: `stack_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the stack pointer becomes 07H, and `busy`, `done`, `ram_re` and `ram_we` are low afterwards until the next accepted operation.
- R2: Push (op 0): the block reads RAM at `dir_addr` in the first cycle after the start edge. In the second cycle it writes that byte at SP+1 and SP becomes SP+1. `done` is high in the third cycle.
- R3: Pop (op 1) to an address other than 81H: the block reads RAM at SP in the first cycle. In the second cycle it writes that byte to `dir_addr` and SP becomes SP-1. `done` is high in the third cycle.
- R4: Pop whose `dir_addr` is 81H (the pointer's own register address): SP ends equal to the byte read, not to the decremented value, and no RAM write occurs. Example: SP=1AH and RAM[1AH]=56H give SP=56H.
- R5: Call (op 2) with `pc_in`: the block writes the low byte at SP+1 and then the high byte at SP+2, and SP rises by 2. `done` is high in the third cycle.
- R6: Return (op 3): the block reads the high byte at SP and then the low byte at SP-1, and SP falls by 2. In the fourth cycle `done` and `pc_load` are high together, and `pc_out` is {high, low}. `irq_restore` stays low.
- R7: Return from interrupt (op 4) behaves as R6 and also raises `irq_restore` in the `done` cycle.
- R8: Pointer load (op 5): SP takes `wr_val`, `done` is high in the first cycle after the start edge, and the RAM port is not used.
- R9: SP arithmetic wraps modulo 256 with no flag: a push at FFH writes address 00H, and a pop at 00H leaves FFH.
- R10: At most one RAM transfer (read or write) happens per cycle, and a `start` raised while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| op | input | 3 | 0 push, 1 pop, 2 call, 3 return, 4 return from interrupt, 5 pointer load |
| dir_addr | input | 8 | Push source / pop destination direct address |
| wr_val | input | 8 | New pointer value for op 5 |
| pc_in | input | 16 | Return address stored by a call |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| sp_out | output | 8 | Current stack pointer |
| pc_out | output | 16 | Return address recovered by a return |
| pc_load | output | 1 | Pulses with `done` after a return |
| irq_restore | output | 1 | Pulses with `done` after a return from interrupt |
| ram_re | output | 1 | RAM read strobe (data on `ram_rdata` next cycle) |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | 8 | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, one cycle after `ram_re` |

## Verification
The bench pops into the pointer's own address. A design that let the decrement win there would leave 19H instead of 56H, and one that still wrote RAM would corrupt location 81H. Calls followed by returns and by byte pops check the byte order. Swapping either order shows up as a byte-reversed `pc_out` or a wrong popped byte. Pushes at FFH and pops at 00H check wrap-around, and a second start raised mid-push checks that a busy engine cannot be restarted. Counting RAM strobes per operation catches an extra or a missing transfer.

// File: rtl/stack_pkg.sv
// Shared types for the stack engine: operation codes and controller states.
package stack_pkg;
    typedef enum logic [2:0] {
        OP_PUSH = 3'd0,
        OP_POP  = 3'd1,
        OP_CALL = 3'd2,
        OP_RET  = 3'd3,
        OP_RETI = 3'd4,
        OP_SPLD = 3'd5
    } stk_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_RD,
        ST_PUSH_WR,
        ST_POP_RD,
        ST_POP_WR,
        ST_CALL,
        ST_RET,
        ST_RET_FIN
    } stk_st_e;
endpackage

// File: rtl/stack_ptr.sv
// Stack pointer register.
// Holds the pointer and offers its incremented value to the controller.
// Assumes the controller never raises inc and dec together. A load
// overrides any step requested in the same cycle.
module stack_ptr #(
    parameter int          W      = 8,
    parameter logic [W-1:0] RST_VAL = 8'h07
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] sp,
    output logic [W-1:0] sp_up
);
    localparam logic [W-1:0] ONE = 1;

    logic [W-1:0] sp_q;

    // Pointer update: load wins over a step; wrap is natural modulo 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)    sp_q <= RST_VAL;
        else if (load) sp_q <= load_val;
        else if (inc)  sp_q <= sp_q + ONE;
        else if (dec)  sp_q <= sp_q - ONE;
    end

    assign sp    = sp_q;
    assign sp_up = sp_q + ONE;
endmodule

// File: rtl/retaddr_reg.sv
// Return-address assembly register.
// Collects NB bytes into one return address. Each byte lane captures the
// RAM read data when its index is selected.
// Assumes the controller selects each lane exactly once per return.
module retaddr_reg #(
    parameter int W  = 8,
    parameter int NB = 2,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_en,
    input  logic [IW-1:0]   cap_idx,
    input  logic [W-1:0]    byte_in,
    output logic [NB*W-1:0] pc_out
);
    for (genvar g = 0; g < NB; g++) begin : g_lane
        logic [W-1:0] lane_q;

        // Capture the lane when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                lane_q <= '0;
            else if (cap_en && cap_idx == IW'(g))      lane_q <= byte_in;
        end

        assign pc_out[g*W +: W] = lane_q;
    end
endmodule

// File: rtl/stack_ctrl.sv
// Stack operation sequencer.
// Accepts one operation at a time and issues at most one RAM transfer per
// cycle. It steers the pointer and the return-address lanes.
// Assumes RAM read data arrives one cycle after the read strobe.
module stack_ctrl
    import stack_pkg::*;
#(
    parameter int           W      = 8,
    parameter int           NB     = 2,
    parameter logic [W-1:0] SP_SFR = 8'h81,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1,
    localparam int PCW = NB * W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic [W-1:0]   dir_addr,
    input  logic [W-1:0]   wr_val,
    input  logic [PCW-1:0] pc_in,
    input  logic [W-1:0]   sp,
    input  logic [W-1:0]   sp_up,
    input  logic [W-1:0]   ram_rdata,
    output logic           sp_inc,
    output logic           sp_dec,
    output logic           sp_load,
    output logic [W-1:0]   sp_load_val,
    output logic           ram_re,
    output logic           ram_we,
    output logic [W-1:0]   ram_addr,
    output logic [W-1:0]   ram_wdata,
    output logic           cap_en,
    output logic [IW-1:0]  cap_idx,
    output logic           busy,
    output logic           done,
    output logic           pc_load,
    output logic           irq_restore
);
    localparam logic [IW-1:0] LAST = IW'(NB - 1);
    localparam logic [IW-1:0] STEP = IW'(1);

    stk_st_e        st_q;
    stk_op_e        op_in;
    logic [W-1:0]   dst_q;
    logic [PCW-1:0] pc_q;
    logic [IW-1:0]  idx_q;
    logic           reti_q;
    logic           cap_v_q;
    logic [IW-1:0]  cap_i_q;
    logic           done_q;
    logic           pcld_q;
    logic           irq_q;

    assign op_in = stk_op_e'(op);

    // Per-state RAM and pointer controls.
    always_comb begin
        sp_inc      = 1'b0;
        sp_dec      = 1'b0;
        sp_load     = 1'b0;
        sp_load_val = wr_val;
        ram_re      = 1'b0;
        ram_we      = 1'b0;
        ram_addr    = '0;
        ram_wdata   = '0;
        case (st_q)
            ST_IDLE: begin
                if (start && op_in == OP_SPLD) sp_load = 1'b1;
            end
            ST_PUSH_RD: begin
                ram_re   = 1'b1;
                ram_addr = dst_q;
            end
            ST_PUSH_WR: begin
                ram_we    = 1'b1;
                ram_addr  = sp_up;
                ram_wdata = ram_rdata;
                sp_inc    = 1'b1;
            end
            ST_POP_RD: begin
                ram_re   = 1'b1;
                ram_addr = sp;
            end
            ST_POP_WR: begin
                sp_dec = 1'b1;
                if (dst_q == SP_SFR) begin
                    sp_load     = 1'b1;
                    sp_load_val = ram_rdata;
                end else begin
                    ram_we    = 1'b1;
                    ram_addr  = dst_q;
                    ram_wdata = ram_rdata;
                end
            end
            ST_CALL: begin
                ram_we    = 1'b1;
                ram_addr  = sp_up;
                ram_wdata = pc_q[idx_q*W +: W];
                sp_inc    = 1'b1;
            end
            ST_RET: begin
                ram_re   = 1'b1;
                ram_addr = sp;
                sp_dec   = 1'b1;
            end
            default: ;
        endcase
    end

    // Sequencing: state, operand latches, byte index and completion pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            dst_q   <= '0;
            pc_q    <= '0;
            idx_q   <= '0;
            reti_q  <= 1'b0;
            cap_v_q <= 1'b0;
            cap_i_q <= '0;
            done_q  <= 1'b0;
            pcld_q  <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            pcld_q  <= 1'b0;
            irq_q   <= 1'b0;
            cap_v_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        case (op_in)
                            OP_PUSH: begin
                                dst_q <= dir_addr;
                                st_q  <= ST_PUSH_RD;
                            end
                            OP_POP: begin
                                dst_q <= dir_addr;
                                st_q  <= ST_POP_RD;
                            end
                            OP_CALL: begin
                                pc_q  <= pc_in;
                                idx_q <= '0;
                                st_q  <= ST_CALL;
                            end
                            OP_RET, OP_RETI: begin
                                idx_q  <= LAST;
                                reti_q <= (op_in == OP_RETI);
                                st_q   <= ST_RET;
                            end
                            OP_SPLD: done_q <= 1'b1;
                            default: ;
                        endcase
                    end
                end
                ST_PUSH_RD: st_q <= ST_PUSH_WR;
                ST_PUSH_WR: begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                ST_POP_RD: st_q <= ST_POP_WR;
                ST_POP_WR: begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                end
                ST_CALL: begin
                    if (idx_q == LAST) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        idx_q <= idx_q + STEP;
                    end
                end
                ST_RET: begin
                    cap_v_q <= 1'b1;
                    cap_i_q <= idx_q;
                    if (idx_q == '0) st_q  <= ST_RET_FIN;
                    else             idx_q <= idx_q - STEP;
                end
                ST_RET_FIN: begin
                    st_q   <= ST_IDLE;
                    done_q <= 1'b1;
                    pcld_q <= 1'b1;
                    irq_q  <= reti_q;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign cap_en      = cap_v_q;
    assign cap_idx     = cap_i_q;
    assign busy        = (st_q != ST_IDLE);
    assign done        = done_q;
    assign pc_load     = pcld_q;
    assign irq_restore = irq_q;
endmodule

// File: rtl/stack_seq.sv
// Upward-growing stack engine, top level.
// Connects the sequencer, the pointer register and the return-address lanes.
// Assumes a byte-wide RAM with a one-cycle read latency. The pointer and the
// RAM data share width W.
module stack_seq #(
    parameter int           W      = 8,
    parameter int           NB     = 2,
    parameter logic [W-1:0] SP_RST = 8'h07,
    parameter logic [W-1:0] SP_SFR = 8'h81,
    localparam int IW  = (NB > 1) ? $clog2(NB) : 1,
    localparam int PCW = NB * W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [2:0]     op,
    input  logic [W-1:0]   dir_addr,
    input  logic [W-1:0]   wr_val,
    input  logic [PCW-1:0] pc_in,
    output logic           busy,
    output logic           done,
    output logic [W-1:0]   sp_out,
    output logic [PCW-1:0] pc_out,
    output logic           pc_load,
    output logic           irq_restore,
    output logic           ram_re,
    output logic           ram_we,
    output logic [W-1:0]   ram_addr,
    output logic [W-1:0]   ram_wdata,
    input  logic [W-1:0]   ram_rdata
);
    logic          w_sp_inc;
    logic          w_sp_dec;
    logic          w_sp_load;
    logic [W-1:0]  w_sp_val;
    logic [W-1:0]  w_sp_up;
    logic          w_cap_en;
    logic [IW-1:0] w_cap_idx;

    stack_ctrl #(.W(W), .NB(NB), .SP_SFR(SP_SFR)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .dir_addr(dir_addr), .wr_val(wr_val), .pc_in(pc_in),
        .sp(sp_out), .sp_up(w_sp_up), .ram_rdata(ram_rdata),
        .sp_inc(w_sp_inc), .sp_dec(w_sp_dec), .sp_load(w_sp_load),
        .sp_load_val(w_sp_val), .ram_re(ram_re), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .cap_en(w_cap_en), .cap_idx(w_cap_idx), .busy(busy), .done(done),
        .pc_load(pc_load), .irq_restore(irq_restore)
    );

    stack_ptr #(.W(W), .RST_VAL(SP_RST)) u_sp (
        .clk(clk), .rst_n(rst_n), .inc(w_sp_inc), .dec(w_sp_dec),
        .load(w_sp_load), .load_val(w_sp_val), .sp(sp_out), .sp_up(w_sp_up)
    );

    retaddr_reg #(.W(W), .NB(NB)) u_ret (
        .clk(clk), .rst_n(rst_n), .cap_en(w_cap_en), .cap_idx(w_cap_idx),
        .byte_in(ram_rdata), .pc_out(pc_out)
    );
endmodule

// File: rtl/stack_seq_chk.sv
// Assertion checker for the stack engine, bound to every stack_seq instance.
// Observes ports plus the pointer controls passed from sequencer to register.
module stack_seq_chk #(
    parameter int           W      = 8,
    parameter logic [W-1:0] SP_RST = 8'h07
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [2:0]   op,
    input logic [W-1:0] wr_val,
    input logic         busy,
    input logic         done,
    input logic         pc_load,
    input logic         irq_restore,
    input logic [W-1:0] sp_out,
    input logic         ram_re,
    input logic         ram_we,
    input logic [W-1:0] ram_addr,
    input logic [W-1:0] ram_rdata,
    input logic         sp_inc,
    input logic         sp_dec,
    input logic         sp_load
);
    localparam logic [W-1:0] ONE = 1;

    // R1: the pointer leaves reset at its reset value
    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> sp_out == SP_RST) else $error("p_reset_val_r1");

    // R2 / R5 / R9: a stack write is pre-incremented, so the new SP is the address written
    p_preinc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && sp_inc) |=> sp_out == $past(ram_addr)) else $error("p_preinc_r2");

    // R6 / R9: a stack read is followed by a post-decrement
    p_postdec_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_re && sp_dec) |=> sp_out == $past(ram_addr) - ONE) else $error("p_postdec_r6");

    // R4: the popped byte wins over the decrement
    p_pop_self_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_load && sp_dec) |=> sp_out == $past(ram_rdata)) else $error("p_pop_self_r4");

    // R4: no RAM write when the pointer itself is the pop destination
    p_pop_self_nowr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_load && sp_dec) |-> !ram_we) else $error("p_pop_self_nowr_r4");

    // R7: interrupt-state restore only comes with a return completion
    p_irq_with_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_restore |-> (pc_load && done)) else $error("p_irq_with_ret_r7");

    // R8: pointer load finishes in one cycle
    p_spld_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && op == 3'd5) |=> (done && sp_out == $past(wr_val)))
        else $error("p_spld_r8");

    // R10: one transfer per cycle
    p_one_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ram_re, ram_we})) else $error("p_one_xfer_r10");

    // R10: completion is reported only from the idle state
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy) else $error("p_done_idle_r10");
endmodule

bind stack_seq stack_seq_chk #(.W(W), .SP_RST(SP_RST)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wr_val(wr_val),
    .busy(busy), .done(done), .pc_load(pc_load), .irq_restore(irq_restore),
    .sp_out(sp_out), .ram_re(ram_re), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_rdata(ram_rdata), .sp_inc(w_sp_inc), .sp_dec(w_sp_dec),
    .sp_load(w_sp_load)
);

// File: tb/stack_seq_tb_top.sv
// Self-checking bench for stack_seq: a vector table followed by directed cases.
module stack_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;
    // {op[2:0], dir_addr[7:0], data[15:0]}
    localparam logic [26:0] VEC [NVEC] = '{
        {3'd5, 8'h00, 16'h0030},
        {3'd0, 8'h40, 16'h0000},
        {3'd0, 8'h41, 16'h0000},
        {3'd2, 8'h00, 16'h1234},
        {3'd1, 8'h60, 16'h0000},
        {3'd1, 8'h61, 16'h0000},
        {3'd2, 8'h00, 16'hABCD},
        {3'd3, 8'h00, 16'h0000},
        {3'd0, 8'h42, 16'h0000},
        {3'd2, 8'h00, 16'h0F0E},
        {3'd4, 8'h00, 16'h0000},
        {3'd1, 8'h62, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = '0;
    logic [7:0]  dir_addr = '0;
    logic [7:0]  wr_val = '0;
    logic [15:0] pc_in = '0;
    logic        busy, done, pc_load, irq_restore, ram_re, ram_we;
    logic [7:0]  sp_out, ram_addr, ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [15:0] pc_out;

    logic [7:0] mem     [256];
    logic [7:0] exp_mem [256];
    logic [7:0] exp_sp;
    int n_cmp = 0;
    int n_bad = 0;
    int n_acc = 0;

    stack_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dir_addr(dir_addr),
        .wr_val(wr_val), .pc_in(pc_in), .busy(busy), .done(done),
        .sp_out(sp_out), .pc_out(pc_out), .pc_load(pc_load),
        .irq_restore(irq_restore), .ram_re(ram_re), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Bench RAM with one-cycle read latency, plus a strobe counter.
    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        if (ram_re) ram_rdata <= mem[ram_addr];
        if (ram_re || ram_we) n_acc <= n_acc + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] o, input logic [7:0] a);
        case (o)
            3'd0: return "R2";
            3'd1: return (a == 8'h81) ? "R4" : "R3";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Run one operation, compare against the model, then update the model.
    task automatic run_op(input logic [2:0] o, input logic [7:0] a, input logic [15:0] d);
        string tag = tag_of(o, a);
        int k;
        int acc0;
        int exp_k;
        int exp_acc;
        logic [7:0] v;
        logic [15:0] exp_pc;
        exp_pc = '0;
        case (o)
            3'd0: begin v = exp_mem[a]; exp_sp = exp_sp + 8'd1; exp_mem[exp_sp] = v;
                        exp_k = 3; exp_acc = 2; end
            3'd1: begin v = exp_mem[exp_sp]; exp_sp = exp_sp - 8'd1;
                        if (a == 8'h81) begin exp_sp = v; exp_acc = 1; end
                        else begin exp_mem[a] = v; exp_acc = 2; end
                        exp_k = 3; end
            3'd2: begin exp_mem[exp_sp + 8'd1] = d[7:0]; exp_mem[exp_sp + 8'd2] = d[15:8];
                        exp_sp = exp_sp + 8'd2; exp_k = 3; exp_acc = 2; end
            3'd3, 3'd4: begin exp_pc = {exp_mem[exp_sp], exp_mem[exp_sp - 8'd1]};
                        exp_sp = exp_sp - 8'd2; exp_k = 4; exp_acc = 2; end
            default: begin exp_sp = d[7:0]; exp_k = 1; exp_acc = 0; end
        endcase
        @(negedge clk);
        acc0 = n_acc;
        start = 1'b1; op = o; dir_addr = a; wr_val = d[7:0]; pc_in = d;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 10) begin @(negedge clk); k++; end
        chk({tag, " done cycle"}, k, exp_k);
        chk({tag, " sp"}, sp_out, exp_sp);
        chk({tag, " ram strobes"}, n_acc - acc0, exp_acc);
        if (o == 3'd3 || o == 3'd4) begin
            chk({tag, " pc_out"}, pc_out, exp_pc);
            chk({tag, " pc_load"}, pc_load, 1);
            chk({tag, " irq_restore"}, irq_restore, (o == 3'd4) ? 1 : 0);
        end
        if (o == 3'd0) chk({tag, " pushed byte"}, mem[exp_sp], exp_mem[exp_sp]);
        if (o == 3'd1 && a != 8'h81) chk({tag, " popped byte"}, mem[a], exp_mem[a]);
        if (o == 3'd2) begin
            chk({tag, " low byte first"}, mem[exp_sp - 8'd1], exp_mem[exp_sp - 8'd1]);
            chk({tag, " high byte"}, mem[exp_sp], exp_mem[exp_sp]);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        exp_sp = 8'h07;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 sp", sp_out, 8'h07);
        chk("R1 busy/done", {busy, done}, 0);
        chk("R1 ram strobes", {ram_re, ram_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sp after release", sp_out, 8'h07);

        for (int i = 0; i < NVEC; i++)
            run_op(VEC[i][26:24], VEC[i][23:16], VEC[i][15:0]);

        // R4: pop into the pointer itself
        run_op(3'd5, 8'h00, 16'h001A);
        @(negedge clk);
        mem[8'h1A] = 8'h56; exp_mem[8'h1A] = 8'h56;
        run_op(3'd1, 8'h81, 16'h0000);
        chk("R4 sp takes popped byte", sp_out, 8'h56);
        chk("R4 location 81H untouched", mem[8'h81], 8'h81 ^ 8'h5A);

        // R9: wrap on push at FFH and pop at 00H
        run_op(3'd5, 8'h00, 16'h00FF);
        run_op(3'd0, 8'h44, 16'h0000);
        chk("R9 push wraps to 00", sp_out, 8'h00);
        chk("R9 byte at 00", mem[8'h00], 8'h44 ^ 8'h5A);
        run_op(3'd1, 8'h63, 16'h0000);
        chk("R9 pop wraps to FF", sp_out, 8'hFF);

        // R10: start while busy is ignored
        run_op(3'd5, 8'h00, 16'h0070);
        @(negedge clk);
        start = 1'b1; op = 3'd0; dir_addr = 8'h45;
        @(negedge clk);
        op = 3'd5; wr_val = 8'h99;
        chk("R10 busy during push", busy, 1);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk("R10 done after push", done, 1);
        chk("R10 sp ignores second start", sp_out, 8'h71);
        chk("R10 pushed byte", mem[8'h71], 8'h45 ^ 8'h5A);
        @(negedge clk);
        chk("R10 no extra done", done, 0);

        // R1: reset in the middle of use
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 sp after mid reset", sp_out, 8'h07);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule